// File: doc/BRIEF.md
# Victim Replication Local Slice Controller

This block manages the local slice that one core owns in a distributed shared L2 cache. The slices of all the cores together make up one shared L2. Each address belongs to one home slice, and the home slice is picked from the low block-address bits just above the line offset. The controller takes two kinds of notice from its own L1: evictions and misses. When the L1 evicts a line, the controller may keep a copy of that victim, called a replica, in the local slice. It does so only when the target set still has an invalid way. A replica never pushes out a valid line.

On an L1 miss, the controller probes the local slice first. A hit returns the line one cycle later and reports whether the line was a replica. A miss in the local slice is forwarded once to the home slice, and further misses are held off until the home response comes back. The home data goes to the L1. It is written into the local slice only when this slice is the home of the address.

Invalidations from the coherence fabric remove any matching line. Replicas therefore need no tracking of their own: the core stays on the sharer list for the line, so it still receives the invalidation.

Top module: `vr_slice_ctrl`

## Requirements
- R1: After reset every line is invalid, `miss_ready` is 1, and `rsp_valid` and `fwd_valid` are 0.
- R2: An eviction whose set (address bits [4:2]) holds an invalid way stores the victim as a replica. A later miss on that address returns the evicted data with `rsp_replica`=1 and raises no forward.
- R3: An eviction into a set with no invalid way is dropped. The lines already in the set keep their data, and a later miss on the dropped address is forwarded.
- R4: An eviction to an address already present in the slice refreshes that line's data and takes no second way.
- R5: A miss accepted while `miss_ready`=1 that hits the slice gives `rsp_valid` for exactly the next cycle, with the line's data. `rsp_replica` is 0 for a line filled from home and 1 for a replica.
- R6: A miss that misses the slice gives a one-cycle `fwd_valid` on the next cycle. It carries the miss address on `fwd_addr` and the home slice (address bits [3:2]) on `fwd_slice`. `miss_ready` then stays 0 and further misses are ignored until the home response is taken.
- R7: A home response taken while a miss is outstanding gives `rsp_valid` on the next cycle, with the response data and `rsp_replica`=0, and `miss_ready` returns to 1 in that same cycle.
- R8: Home response data is written into the slice as a non-replica line only when the home slice equals `SLICE_ID` (default 1). For any other home it is not written into the slice.
- R9: An invalidation removes a matching line, so a later miss on that address is forwarded. An invalidation that matches no line leaves every other line unchanged.
- R10: An invalidation and a miss to the same resident line in the same cycle give a forward, not a hit.
- R11: When a home fill and an eviction target the same set in the same cycle and only one way is free, the fill takes that way and the replica is dropped.
- R12: A home response that arrives with no miss outstanding is ignored: no `rsp_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | L1 eviction notice |
| evict_addr | input | ADDR_W | Address of the evicted line |
| evict_data | input | DATA_W | Data of the evicted line |
| miss_valid | input | 1 | L1 miss request |
| miss_ready | output | 1 | Controller can take a miss |
| miss_addr | input | ADDR_W | Address of the miss |
| rsp_valid | output | 1 | Data returned to the L1 |
| rsp_data | output | DATA_W | Returned line data |
| rsp_replica | output | 1 | The returned data came from a replica |
| fwd_valid | output | 1 | Request forwarded to the home slice |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_slice | output | SLICE_W | Home slice number |
| home_rsp_valid | input | 1 | Response from the home slice |
| home_rsp_data | input | DATA_W | Response data |
| inv_valid | input | 1 | Invalidation from the coherence fabric |
| inv_addr | input | ADDR_W | Address to invalidate |

## Verification
The misses are tried against four kinds of line: a replica, a line filled from home, a dropped victim and an invalidated line. Each hit-or-forward outcome and each `rsp_replica` value therefore shows which of these paths stored or removed the line. Refresh evictions followed by a second eviction into the same set tell an in-place update apart from a duplicate allocation. Collisions in a single cycle, one an invalidation with a miss and the other a home fill with an eviction, show which update takes precedence. A home miss compared with a miss to another slice shows whether the local fill is gated correctly.

// File: rtl/vr_pkg.sv
package vr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vr_state_e;

    // lookup port numbering shared by the top and its generate loop
    localparam int LK_MISS  = 0;
    localparam int LK_EVICT = 1;
    localparam int LK_INV   = 2;
    localparam int LK_FILL  = 3;
    localparam int LK_NUM   = 4;
endpackage

// File: rtl/vr_addr_split.sv
module vr_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int SET_W  = 3,
    localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    assign set_idx = addr[OFF_W +: SET_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/vr_way_match.sv
module vr_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 11
) (
    input  logic [WAYS*TAG_W-1:0] row_tags,
    input  logic [WAYS-1:0]       row_vld,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = row_vld[w] && (row_tags[w*TAG_W +: TAG_W] == tag);
    end
endmodule

// File: rtl/vr_free_way.sv
module vr_free_way #(
    parameter int WAYS     = 2,
    parameter bit FROM_TOP = 1'b0,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  row_vld,
    output logic             found,
    output logic [WAY_W-1:0] idx
);
    if (FROM_TOP) begin : g_high
        // the last free way seen while scanning upward wins
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (!row_vld[w]) begin
                    found = 1'b1;
                    idx   = WAY_W'(w);
                end
            end
        end
    end else begin : g_low
        // the last free way seen while scanning downward wins
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!row_vld[w]) begin
                    found = 1'b1;
                    idx   = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/vr_slice_ctrl.sv
module vr_slice_ctrl
    import vr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 2,
    parameter int NUM_SLICES = 4,
    parameter int SLICE_ID   = 1,
    parameter int SETS       = 8,
    parameter int WAYS       = 2,
    localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [DATA_W-1:0] evict_data,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_replica,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [SLICE_W-1:0] fwd_slice,
    input  logic              home_rsp_valid,
    input  logic [DATA_W-1:0] home_rsp_data,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        vr_state_e         st;
        logic [ADDR_W-1:0] pend;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic              rsp_rep;
        logic              fwd_v;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  tag_d [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_d [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];
    logic [WAYS-1:0]   vld_d [SETS];
    logic [WAYS-1:0]   vld_q [SETS];
    logic [WAYS-1:0]   rep_d [SETS];
    logic [WAYS-1:0]   rep_q [SETS];

    // ---------------- lookup ports ----------------
    logic [ADDR_W-1:0] lk_addr [LK_NUM];
    logic [SET_W-1:0]  lk_set  [LK_NUM];
    logic [TAG_W-1:0]  lk_tag  [LK_NUM];
    logic [WAYS-1:0]   lk_hit  [LK_NUM];

    assign lk_addr[LK_MISS]  = miss_addr;
    assign lk_addr[LK_EVICT] = evict_addr;
    assign lk_addr[LK_INV]   = inv_addr;
    assign lk_addr[LK_FILL]  = ctl_q.pend;

    for (genvar k = 0; k < LK_NUM; k++) begin : g_lookup
        logic [WAYS*TAG_W-1:0] row;

        vr_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_split (
            .addr    (lk_addr[k]),
            .set_idx (lk_set[k]),
            .tag     (lk_tag[k])
        );

        always_comb begin
            for (int w = 0; w < WAYS; w++) begin
                row[w*TAG_W +: TAG_W] = tag_q[lk_set[k]][w];
            end
        end

        vr_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
            .row_tags (row),
            .row_vld  (vld_q[lk_set[k]]),
            .tag      (lk_tag[k]),
            .hit      (lk_hit[k])
        );
    end

    // ---------------- way choosers ----------------
    logic             ev_free;
    logic [WAY_W-1:0] ev_free_way;
    logic             fl_free;
    logic [WAY_W-1:0] fl_free_way;

    vr_free_way #(.WAYS(WAYS), .FROM_TOP(1'b1)) u_ev_free (
        .row_vld (vld_q[lk_set[LK_EVICT]]),
        .found   (ev_free),
        .idx     (ev_free_way)
    );

    vr_free_way #(.WAYS(WAYS), .FROM_TOP(1'b0)) u_fl_free (
        .row_vld (vld_q[lk_set[LK_FILL]]),
        .found   (fl_free),
        .idx     (fl_free_way)
    );

    // ---------------- next-state logic ----------------
    logic [WAYS-1:0]  miss_hit_v;
    logic [WAY_W-1:0] miss_way;
    logic [WAY_W-1:0] fill_way;
    logic [WAY_W-1:0] ev_hit_way;
    logic             accept;
    logic             fill_go;
    logic             fill_alloc;
    logic             fill_same_set;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rsp_v   = 1'b0;
        ctl_d.fwd_v   = 1'b0;
        tag_d         = tag_q;
        dat_d         = dat_q;
        vld_d         = vld_q;
        rep_d         = rep_q;

        // a same-cycle invalidation of the probed line turns the hit into a miss
        miss_hit_v = lk_hit[LK_MISS];
        if (inv_valid && (lk_set[LK_INV] == lk_set[LK_MISS])) begin
            miss_hit_v = lk_hit[LK_MISS] & ~lk_hit[LK_INV];
        end

        miss_way   = '0;
        ev_hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (miss_hit_v[w])        miss_way   = WAY_W'(w);
            if (lk_hit[LK_EVICT][w])  ev_hit_way = WAY_W'(w);
        end

        // fill reuses a matching way, else the lowest free way, else way 0
        fill_way = '0;
        if (fl_free) fill_way = fl_free_way;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hit[LK_FILL][w]) fill_way = WAY_W'(w);
        end

        accept        = miss_valid && (ctl_q.st == ST_IDLE);
        fill_go       = home_rsp_valid && (ctl_q.st == ST_WAIT);
        fill_alloc    = fill_go &&
                        (ctl_q.pend[OFF_W +: SLICE_W] == SLICE_W'(SLICE_ID));
        fill_same_set = fill_alloc && (lk_set[LK_FILL] == lk_set[LK_EVICT]);

        // L1 miss: local probe, then forward
        if (accept) begin
            if (|miss_hit_v) begin
                ctl_d.rsp_v   = 1'b1;
                ctl_d.rsp_d   = dat_q[lk_set[LK_MISS]][miss_way];
                ctl_d.rsp_rep = rep_q[lk_set[LK_MISS]][miss_way];
            end else begin
                ctl_d.fwd_v = 1'b1;
                ctl_d.st    = ST_WAIT;
                ctl_d.pend  = miss_addr;
            end
        end

        // home response: to the L1 always, into the slice only when home
        if (fill_go) begin
            ctl_d.rsp_v   = 1'b1;
            ctl_d.rsp_d   = home_rsp_data;
            ctl_d.rsp_rep = 1'b0;
            ctl_d.st      = ST_IDLE;
            if (fill_alloc) begin
                vld_d[lk_set[LK_FILL]][fill_way] = 1'b1;
                rep_d[lk_set[LK_FILL]][fill_way] = 1'b0;
                tag_d[lk_set[LK_FILL]][fill_way] = lk_tag[LK_FILL];
                dat_d[lk_set[LK_FILL]][fill_way] = home_rsp_data;
            end
        end

        // L1 eviction: refresh in place or take a free way, never displace
        if (evict_valid) begin
            if (|lk_hit[LK_EVICT]) begin
                if (!(fill_same_set && (fill_way == ev_hit_way))) begin
                    dat_d[lk_set[LK_EVICT]][ev_hit_way] = evict_data;
                end
            end else if (ev_free && !(fill_same_set && (fill_way == ev_free_way))) begin
                vld_d[lk_set[LK_EVICT]][ev_free_way] = 1'b1;
                rep_d[lk_set[LK_EVICT]][ev_free_way] = 1'b1;
                tag_d[lk_set[LK_EVICT]][ev_free_way] = lk_tag[LK_EVICT];
                dat_d[lk_set[LK_EVICT]][ev_free_way] = evict_data;
            end
        end

        // invalidation is applied last and wins over the other updates
        if (inv_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (lk_hit[LK_INV][w]) vld_d[lk_set[LK_INV]][w] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, pend: '0, rsp_v: 1'b0, rsp_d: '0,
                       rsp_rep: 1'b0, fwd_v: 1'b0};
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rep_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    dat_q[s][w] <= '0;
                end
            end
        end else begin
            ctl_q <= ctl_d;
            tag_q <= tag_d;
            dat_q <= dat_d;
            vld_q <= vld_d;
            rep_q <= rep_d;
        end
    end

    assign miss_ready  = (ctl_q.st == ST_IDLE);
    assign rsp_valid   = ctl_q.rsp_v;
    assign rsp_data    = ctl_q.rsp_d;
    assign rsp_replica = ctl_q.rsp_rep;
    assign fwd_valid   = ctl_q.fwd_v;
    assign fwd_addr    = ctl_q.pend;
    assign fwd_slice   = ctl_q.pend[OFF_W +: SLICE_W];
endmodule

// File: rtl/vr_slice_chk.sv
module vr_slice_chk (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic miss_ready,
    input logic rsp_valid,
    input logic rsp_replica,
    input logic fwd_valid,
    input logic home_rsp_valid
);
    AST_ACCEPT_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (rsp_valid ^ fwd_valid)); // R5
    AST_FWD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid); // R6
    AST_FWD_BLOCKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !miss_ready); // R6
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_ready && !home_rsp_valid) |=> (!miss_ready && !rsp_valid)); // R6
    AST_HOME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_ready && home_rsp_valid) |=> (rsp_valid && miss_ready && !rsp_replica)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ready && !miss_valid) |=> (!rsp_valid && !fwd_valid)); // R12
endmodule

bind vr_slice_ctrl vr_slice_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .rsp_valid      (rsp_valid),
    .rsp_replica    (rsp_replica),
    .fwd_valid      (fwd_valid),
    .home_rsp_valid (home_rsp_valid)
);

// File: tb/vr_slice_ctrl_bench.sv
module vr_slice_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evict_valid = 1'b0;
    logic [15:0] evict_addr = '0;
    logic [31:0] evict_data = '0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [15:0] miss_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_replica;
    logic        fwd_valid;
    logic [15:0] fwd_addr;
    logic [1:0]  fwd_slice;
    logic        home_rsp_valid = 1'b0;
    logic [31:0] home_rsp_data = '0;
    logic        inv_valid = 1'b0;
    logic [15:0] inv_addr = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vr_slice_ctrl u_vr_slice_ctrl (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_replica(rsp_replica),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_slice(fwd_slice),
        .home_rsp_valid(home_rsp_valid), .home_rsp_data(home_rsp_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    function automatic logic [15:0] mk(input int tag, input int set);
        return {11'(tag), 3'(set), 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_evict(input logic [15:0] a, input logic [31:0] d);
        evict_valid = 1'b1; evict_addr = a; evict_data = d;
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [15:0] a);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [15:0] a,
                              input logic [31:0] d, input logic rep);
        miss_valid = 1'b1; miss_addr = a;
        @(negedge clk);
        miss_valid = 1'b0;
        chk({req, " hit rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit no fwd"}, 32'(fwd_valid), 32'd0);
        chk({req, " hit data"}, rsp_data, d);
        chk({req, " hit replica flag"}, 32'(rsp_replica), 32'(rep));
    endtask

    task automatic expect_fwd(input string req, input logic [15:0] a);
        miss_valid = 1'b1; miss_addr = a;
        @(negedge clk);
        miss_valid = 1'b0;
        chk({req, " fwd_valid"}, 32'(fwd_valid), 32'd1);
        chk({req, " no rsp on fwd"}, 32'(rsp_valid), 32'd0);
        chk({req, " fwd_addr"}, 32'(fwd_addr), 32'(a));
        chk({req, " fwd_slice"}, 32'(fwd_slice), 32'(a[3:2]));
        chk({req, " ready low"}, 32'(miss_ready), 32'd0);
    endtask

    task automatic home_reply(input string req, input logic [31:0] d);
        home_rsp_valid = 1'b1; home_rsp_data = d;
        @(negedge clk);
        home_rsp_valid = 1'b0;
        chk({req, " reply rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " reply data"}, rsp_data, d);
        chk({req, " reply not replica"}, 32'(rsp_replica), 32'd0);
        chk({req, " reply ready back"}, 32'(miss_ready), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(miss_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 fwd_valid", 32'(fwd_valid), 32'd0);
        expect_fwd("R1 empty slice", mk(4, 6));
        home_reply("R1", 32'h0000_0046);
    endtask

    task automatic t_replica;
        do_evict(mk(1, 2), 32'hA1);
        expect_hit("R2", mk(1, 2), 32'hA1, 1'b1);
    endtask

    task automatic t_full_set;
        do_evict(mk(1, 3), 32'hB1);
        do_evict(mk(2, 3), 32'hB2);
        do_evict(mk(3, 3), 32'hB3);
        chk("R3 eviction makes no fwd", 32'(fwd_valid), 32'd0);
        expect_fwd("R3 dropped victim", mk(3, 3));
        // R6: misses held off while waiting
        miss_valid = 1'b1; miss_addr = mk(1, 3);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R6 ready held low", 32'(miss_ready), 32'd0);
            chk("R6 no rsp while waiting", 32'(rsp_valid), 32'd0);
            chk("R6 no second fwd", 32'(fwd_valid), 32'd0);
        end
        miss_valid = 1'b0;
        home_reply("R7", 32'hC3);
        expect_hit("R3 way1 intact", mk(1, 3), 32'hB1, 1'b1);
        expect_hit("R3 way0 intact", mk(2, 3), 32'hB2, 1'b1);
        expect_fwd("R8 remote not filled", mk(3, 3));
        home_reply("R8", 32'hC4);
    endtask

    task automatic t_refresh;
        do_evict(mk(5, 4), 32'h50);
        do_evict(mk(5, 4), 32'h51);
        do_evict(mk(6, 4), 32'h60);
        expect_hit("R4 refreshed data", mk(5, 4), 32'h51, 1'b1);
        expect_hit("R4 way still free", mk(6, 4), 32'h60, 1'b1);
    endtask

    task automatic t_home_fill;
        expect_fwd("R8 home miss", mk(7, 1));
        home_reply("R8", 32'h71);
        expect_hit("R5 home line", mk(7, 1), 32'h71, 1'b0);
    endtask

    task automatic t_inval;
        do_inv(mk(9, 2));
        expect_hit("R9 unrelated kept", mk(1, 2), 32'hA1, 1'b1);
        do_inv(mk(7, 1));
        expect_fwd("R9 invalidated", mk(7, 1));
        home_reply("R9", 32'h72);
    endtask

    task automatic t_inv_race;
        miss_valid = 1'b1; miss_addr = mk(1, 2);
        inv_valid = 1'b1; inv_addr = mk(1, 2);
        @(negedge clk);
        miss_valid = 1'b0; inv_valid = 1'b0;
        chk("R10 race forwards", 32'(fwd_valid), 32'd1);
        chk("R10 race no hit", 32'(rsp_valid), 32'd0);
        home_reply("R10", 32'h12);
        expect_fwd("R10 line gone", mk(1, 2));
        home_reply("R10", 32'h13);
    endtask

    task automatic t_fill_vs_evict;
        do_evict(mk(8, 5), 32'h80);
        expect_fwd("R11 home miss", mk(9, 5));
        evict_valid = 1'b1; evict_addr = mk(10, 5); evict_data = 32'hA0;
        home_reply("R11", 32'h90);
        evict_valid = 1'b0;
        expect_hit("R11 fill won", mk(9, 5), 32'h90, 1'b0);
        expect_hit("R11 old replica", mk(8, 5), 32'h80, 1'b1);
        expect_fwd("R11 replica dropped", mk(10, 5));
        home_reply("R11", 32'hA5);
    endtask

    task automatic t_idle_rsp;
        home_rsp_valid = 1'b1; home_rsp_data = 32'hDEAD;
        @(negedge clk);
        home_rsp_valid = 1'b0;
        chk("R12 stray reply ignored", 32'(rsp_valid), 32'd0);
        chk("R12 ready stays", 32'(miss_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_replica();
        t_full_set();
        t_refresh();
        t_home_fill();
        t_inval();
        t_inv_race();
        t_fill_vs_evict();
        t_idle_rsp();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule